// File: doc/BRIEF.md
# Four-Floor Elevator Car Controller

This block drives one elevator car over four floors, numbered 0 to 3. Each clock cycle it looks at the live floor request lines and the emergency-stop input, then decides whether the car rests, climbs one floor or descends one floor. Requests are not latched. When several lines are raised at once, a priority encoder reduces them to a single target floor, and the highest floor wins. The controller compares that target with the registered current floor and chooses the direction.

All outputs are registered: the floor, the two motor commands, the door command and a 2-bit state code. The door may open only while the car rests. Emergency stop takes effect on the next clock edge from any state. It freezes the car at its floor with the motors off and the door shut, and it holds until the input drops. After release the car first rests at its floor for one cycle before it moves again.

Top module: `elevator_ctrl`

## Requirements
- R1: Synchronous reset takes priority over every other input. On the edge where it is sampled it sets floor 0, door open, both motors off and state code 0 (rest).
- R2: Request bit i asks for floor i. When several bits are set, the highest set index is the target. For example, 0101 targets floor 2 and 0011 targets floor 1.
- R3: When the target is above the current floor and emergency stop is low, the next edge raises the floor by one, sets state code 1 (climb) and motor_up, and closes the door.
- R4: When the target is below the current floor and emergency stop is low, the next edge lowers the floor by one, sets state code 2 (descend) and motor_down, and closes the door.
- R5: When the target equals the current floor, or no request bit is set, the next edge gives state code 0, door open, both motors off and an unchanged floor.
- R6: Emergency stop sampled high on an edge gives state code 3, both motors off, door closed and an unchanged floor. This applies from any state and lasts for as long as the input stays high.
- R7: On the first edge with emergency stop low after state code 3, the car goes to state code 0 at the same floor with the door open, whatever is requested.
- R8: motor_up and motor_down are never high together, and door_open is high only in state code 0.
- R9: Requests are re-evaluated every cycle. A change of request during travel redirects the car on the next edge, including a reversal of direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| floor_req | input | FLOORS (4) | Live request lines, bit i = floor i |
| estop | input | 1 | Emergency stop, active high |
| cur_floor | output | FLOOR_W (2) | Registered current floor |
| motor_up | output | 1 | Climb command |
| motor_down | output | 1 | Descend command |
| door_open | output | 1 | Door command, high only at rest |
| car_state | output | 2 | 0 rest, 1 climb, 2 descend, 3 emergency |

## Verification
A full climb from floor 0 to floor 3 and a descent back tell the single-step rule apart from jumps and show that the car stops exactly on arrival. Requests with several bits set (0101, 0011) separate highest-index priority from lowest-index priority. Emergency stop is applied both while the car rests and while it moves, then released with a request still pending, which tells an immediate resumption apart from the required rest cycle. Reset is asserted together with emergency stop and during travel, and a reversal of the request mid-climb confirms that requests are not latched.

// File: rtl/elevator_pkg.sv
package elevator_pkg;
  typedef enum logic [1:0] {
    CAR_REST    = 2'd0,
    CAR_CLIMB   = 2'd1,
    CAR_DESCEND = 2'd2,
    CAR_HALT    = 2'd3
  } car_state_t;
endpackage

// File: rtl/req_prio_enc.sv
module req_prio_enc #(
  parameter int FLOORS  = 4,
  parameter int FLOOR_W = $clog2(FLOORS)
) (
  input  logic [FLOORS-1:0]  req,
  output logic [FLOOR_W-1:0] target,
  output logic               any_req
);
  // later (higher) indices overwrite lower ones: highest floor wins
  always_comb begin
    target = '0;
    for (int i = 0; i < FLOORS; i++) begin
      if (req[i]) target = FLOOR_W'(i);
    end
  end

  assign any_req = |req;

  always_comb begin
    if (any_req) begin
      assert_enc_top_R2: assert ((req >> target) == FLOORS'(1))
        else $error("encoder did not pick highest set request");
    end
  end
endmodule

// File: rtl/car_fsm.sv
module car_fsm
  import elevator_pkg::*;
#(
  parameter int FLOORS  = 4,
  parameter int FLOOR_W = $clog2(FLOORS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FLOOR_W-1:0] target,
  input  logic               any_req,
  input  logic               estop,
  output logic [FLOOR_W-1:0] floor_q,
  output logic               up_q,
  output logic               down_q,
  output logic               door_q,
  output car_state_t         state_q
);
  localparam logic [FLOOR_W-1:0] STEP = FLOOR_W'(1);

  car_state_t         state_d;
  logic [FLOOR_W-1:0] floor_d;

  always_comb begin
    state_d = CAR_REST;
    floor_d = floor_q;
    if (estop) begin
      state_d = CAR_HALT;
    end else if (state_q == CAR_HALT) begin
      state_d = CAR_REST;               // one rest cycle after release
    end else if (any_req && target > floor_q) begin
      state_d = CAR_CLIMB;
      floor_d = floor_q + STEP;
    end else if (any_req && target < floor_q) begin
      state_d = CAR_DESCEND;
      floor_d = floor_q - STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CAR_REST;
      floor_q <= '0;
      up_q    <= 1'b0;
      down_q  <= 1'b0;
      door_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      floor_q <= floor_d;
      up_q    <= (state_d == CAR_CLIMB);
      down_q  <= (state_d == CAR_DESCEND);
      door_q  <= (state_d == CAR_REST);
    end
  end

  assert_motor_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(up_q && down_q));

  assert_door_rest_R8: assert property (@(posedge clk) disable iff (rst)
    door_q |-> (state_q == CAR_REST) && !up_q && !down_q);

  assert_climb_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && state_q == CAR_CLIMB) |-> floor_q == $past(floor_q) + STEP);

  assert_descend_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && state_q == CAR_DESCEND) |-> floor_q == $past(floor_q) - STEP);

  assert_halt_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(estop)) |->
      (state_q == CAR_HALT) && !up_q && !down_q && !door_q && $stable(floor_q));

  assert_release_rest_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == CAR_HALT && !estop) |=> (state_q == CAR_REST) && $stable(floor_q));
endmodule

// File: rtl/elevator_ctrl.sv
module elevator_ctrl
  import elevator_pkg::*;
#(
  parameter int FLOORS  = 4,
  parameter int FLOOR_W = $clog2(FLOORS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FLOORS-1:0]  floor_req,
  input  logic               estop,
  output logic [FLOOR_W-1:0] cur_floor,
  output logic               motor_up,
  output logic               motor_down,
  output logic               door_open,
  output logic [1:0]         car_state
);
  logic [FLOOR_W-1:0] tgt;
  logic               any_req;
  car_state_t         st;

  req_prio_enc #(.FLOORS(FLOORS), .FLOOR_W(FLOOR_W)) u_enc (
    .req     (floor_req),
    .target  (tgt),
    .any_req (any_req)
  );

  car_fsm #(.FLOORS(FLOORS), .FLOOR_W(FLOOR_W)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .target  (tgt),
    .any_req (any_req),
    .estop   (estop),
    .floor_q (cur_floor),
    .up_q    (motor_up),
    .down_q  (motor_down),
    .door_q  (door_open),
    .state_q (st)
  );

  assign car_state = st;
endmodule

// File: tb/elevator_ctrl_bench.sv
module elevator_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] floor_req = '0;
  logic       estop = 1'b0;
  logic [1:0] cur_floor;
  logic       motor_up, motor_down, door_open;
  logic [1:0] car_state;

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  elevator_ctrl u_elevator_ctrl (
    .clk(clk), .rst(rst), .floor_req(floor_req), .estop(estop),
    .cur_floor(cur_floor), .motor_up(motor_up), .motor_down(motor_down),
    .door_open(door_open), .car_state(car_state)
  );

  // {rst, estop, req[3:0], floor[1:0], state[1:0], up, down, door}
  localparam logic [12:0] VEC [NVEC] = '{
    13'b1_0_0000_00_00_0_0_1, // R1 reset
    13'b0_0_1000_01_01_1_0_0, // R3 climb
    13'b0_0_1000_10_01_1_0_0, // R3
    13'b0_0_1000_11_01_1_0_0, // R3
    13'b0_0_1000_11_00_0_0_1, // R5 arrival
    13'b0_0_0001_10_10_0_1_0, // R4 descend
    13'b0_0_0001_01_10_0_1_0, // R4
    13'b0_1_0001_01_11_0_0_0, // R6 halt while moving
    13'b0_1_0001_01_11_0_0_0, // R6 held
    13'b0_0_0001_01_00_0_0_1, // R7 release rests first
    13'b0_0_0001_00_10_0_1_0, // R4
    13'b0_0_0001_00_00_0_0_1, // R5 arrival
    13'b0_0_0101_01_01_1_0_0, // R2 0101 -> floor 2
    13'b0_0_0101_10_01_1_0_0, // R2
    13'b0_0_0101_10_00_0_0_1, // R5
    13'b0_0_0000_10_00_0_0_1, // R5 no request
    13'b0_0_1000_11_01_1_0_0, // R3
    13'b0_0_1000_11_00_0_0_1, // R5
    13'b0_0_0011_10_10_0_1_0, // R2 0011 -> floor 1
    13'b0_0_0001_01_10_0_1_0, // R9 retarget while descending
    13'b0_0_1000_10_01_1_0_0, // R9 reversal
    13'b0_1_1000_10_11_0_0_0, // R6
    13'b1_1_1000_00_00_0_0_1, // R1 reset beats estop
    13'b0_0_0000_00_00_0_0_1  // R5
  };

  task automatic check(input string req_tag, input logic [6:0] exp);
    logic [6:0] act;
    act = {cur_floor, car_state, motor_up, motor_down, door_open};
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got floor/state/up/dn/door=%b expected %b", req_tag, act, exp);
    end
    if (motor_up && motor_down) begin
      miscompares++;
      $display("FAIL R8: both motors high, got %b%b expected not 11", motor_up, motor_down);
    end
  endtask

  initial begin
    fork
      begin
        for (int k = 0; k < NVEC; k++) begin
          {rst, estop, floor_req} = VEC[k][12:7];
          @(negedge clk);
          check($sformatf("vector %0d (R1..R9 table)", k), VEC[k][6:0]);
        end
        // directed: reset in the middle of a climb (R1)
        rst = 1'b0; estop = 1'b0; floor_req = 4'b1000;
        @(negedge clk); check("R3 directed climb", 7'b01_01_1_0_0);
        @(negedge clk); check("R3 directed climb", 7'b10_01_1_0_0);
        rst = 1'b1;
        @(negedge clk); check("R1 reset mid-travel", 7'b00_00_0_0_1);
        // directed: long emergency hold at floor 0, pending request (R6, R7)
        rst = 1'b0; estop = 1'b1; floor_req = 4'b0100;
        for (int c = 0; c < 5; c++) begin
          @(negedge clk); check("R6 long hold", 7'b00_11_0_0_0);
        end
        estop = 1'b0;
        @(negedge clk); check("R7 release", 7'b00_00_0_0_1);
        @(negedge clk); check("R3 resume after release", 7'b01_01_1_0_0);
        done = 1'b1;
      end
      begin
        repeat (2000) @(posedge clk);
        if (!done) begin
          miscompares++;
          $display("FAIL watchdog: got timeout expected completion");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule